// File: doc/BRIEF.md
# Disciplined Local Time Counter

This block keeps local time as a sub-second cycle count and a seconds count, both running on the system clock (nominally 100 MHz). A whole-second strobe from an external time reference, together with a reference-valid flag, is used to measure how far the local oscillator is off frequency. A signed correction value is learned from these measurements. The first measurement sets it in one coarse step. Every later measurement adds a small signed fine trim to it. Decoding the reference itself happens elsewhere; this block sees only the strobe and the flag.

The correction is never applied as a jump. A positive correction means the oscillator is fast: the counter withholds that many single-cycle increments each second. A negative correction means the oscillator is slow: the counter adds that many extra increments each second, making those cycles advance by two. In both cases an accumulator spaces these events evenly over the nominal second. Each accepted strobe realigns the sub-second count to zero. When the reference goes away, the learned correction keeps being applied, so local time holds its accuracy in holdover. A lock flag reports that the measured residual error has stayed small for several seconds in a row.

Top module: `disc_time_counter`

## Requirements
- R1: After reset the sub-second count, seconds count, correction value and lock flag are all zero.
- R2: With no correction in force, the sub-second count advances by one every cycle through 0 to NOM_CYCLES-1. Each time it wraps, the seconds count increments.
- R3: An accepted strobe sets the sub-second count to 0 on the clock edge where the strobe is sampled. If the count before that edge was at least NOM_CYCLES/2, the seconds count increments at the same edge; otherwise it is left unchanged. The first strobe after reset, or after the reference-valid flag returns, is accepted and only realigns; it makes no measurement.
- R4: The interval P is the number of clock edges between two accepted strobes. The first measurement after reset sets the correction to P-NOM_CYCLES, with a positive value meaning the oscillator is fast.
- R5: Each later measurement computes the residual P-NOM_CYCLES-correction. It adds that residual to the correction, clamped to plus or minus MAX_TRIM.
- R6: Take c as the correction in force and j as the number of cycles since the last realignment. The total advance is then j-floor(j*c/NOM_CYCLES) for c>=0, or j+floor(j*|c|/NOM_CYCLES) for c<0. The sub-second count shows this total modulo NOM_CYCLES, and the seconds count carries the quotient.
- R7: A strobe that arrives fewer than NOM_CYCLES-MAX_DEV edges after the previous base is ignored. Time, correction, lock and the interval base are all unchanged.
- R8: A strobe that arrives more than NOM_CYCLES+MAX_DEV edges after the base does not realign the count and does not change the correction. It clears the lock and starts a new interval base.
- R9: The lock flag is set once LOCK_SECS consecutive fine measurements each have a residual magnitude of at most LOCK_THR. A larger residual, a late strobe, or a low reference-valid flag clears it.
- R10: While reference-valid is low, strobes are ignored and the stored correction is retained and still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_strobe | input | 1 | One-cycle whole-second pulse from the reference |
| ref_ok | input | 1 | Reference present and trusted |
| sub_count | output | SUB_W | Sub-second count, 0 to NOM_CYCLES-1 |
| sec_count | output | SEC_W | Seconds count |
| corr_value | output | CORR_W | Signed correction in cycles per second |
| locked | output | 1 | Residual error has stayed within threshold |

## Verification
The hardest situation to reach is lock followed by a disturbance. It needs a coarse step, several fine trims that converge, and then a glitch strobe, a late strobe or a reference dropout, all in the right order. The stimulus gets there with a scripted chain of strobe intervals: 1099, then 1108 (a trim that gets clamped), then 1108, 1106 and 1106. After that it injects an early strobe, a late strobe and a holdover stretch. Correction spreading is checked at chosen points inside a second, for both a positive and a negative correction, and across a seconds wrap.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic {PH_COARSE = 1'b0, PH_FINE = 1'b1} phase_e;
endpackage

// File: rtl/dtc_interval_meter.sv
module dtc_interval_meter #(
   parameter int unsigned NOM_CYCLES = 100_000_000,
   parameter int unsigned MAX_DEV    = 1000,
   parameter int unsigned CNT_W      = 28,
   parameter int unsigned CORR_W     = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     strobe,
   input  logic                     ref_ok,
   output logic                     take,
   output logic                     measured,
   output logic                     late_rej,
   output logic signed [CORR_W-1:0] err
);
   localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(NOM_CYCLES - MAX_DEV);
   localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(NOM_CYCLES + MAX_DEV);
   localparam logic [CNT_W-1:0] NOM_V  = CNT_W'(NOM_CYCLES);
   localparam logic [CNT_W-1:0] GAP_MX = '1;

   logic [CNT_W-1:0] gap_q;
   logic             have_prev_q;
   logic             hit, early, late, restart;
   logic signed [CNT_W:0] diff;

   always_comb begin
      hit      = strobe && ref_ok;
      early    = have_prev_q && (gap_q < LO_LIM);
      late     = have_prev_q && (gap_q > HI_LIM);
      restart  = hit && !early;
      take     = restart && !late;
      measured = take && have_prev_q;
      late_rej = restart && late;
      diff     = $signed({1'b0, gap_q}) - $signed({1'b0, NOM_V});
      err      = diff[CORR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q       <= '0;
         have_prev_q <= 1'b0;
      end else begin
         if (restart) gap_q <= CNT_W'(1);
         else if (gap_q != GAP_MX) gap_q <= gap_q + CNT_W'(1);
         if (!ref_ok) have_prev_q <= 1'b0;
         else if (restart) have_prev_q <= 1'b1;
      end
   end
endmodule

// File: rtl/dtc_corr_filter.sv
module dtc_corr_filter
   import dtc_pkg::*;
#(
   parameter int unsigned CORR_W    = 12,
   parameter int unsigned MAX_TRIM  = 64,
   parameter int unsigned LOCK_THR  = 20,
   parameter int unsigned LOCK_SECS = 4,
   parameter int unsigned STRK_W    = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ref_ok,
   input  logic                     measured,
   input  logic                     late_rej,
   input  logic signed [CORR_W-1:0] err,
   output logic signed [CORR_W-1:0] corr,
   output logic                     fine_ph,
   output logic                     locked
);
   localparam logic signed [CORR_W:0] TLIM = (CORR_W+1)'(MAX_TRIM);
   localparam logic signed [CORR_W:0] LTHR = (CORR_W+1)'(LOCK_THR);
   localparam logic [STRK_W-1:0]      SMAX = STRK_W'(LOCK_SECS);

   phase_e                  ph_q;
   logic signed [CORR_W-1:0] corr_q;
   logic [STRK_W-1:0]       strk_q;
   logic signed [CORR_W:0]  resid, trim;
   logic                    resid_ok;

   always_comb begin
      resid = {err[CORR_W-1], err} - {corr_q[CORR_W-1], corr_q};
      if (resid > TLIM)       trim = TLIM;
      else if (resid < -TLIM) trim = -TLIM;
      else                    trim = resid;
      resid_ok = (resid <= LTHR) && (resid >= -LTHR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_COARSE;
         corr_q <= '0;
         strk_q <= '0;
      end else begin
         if (measured) begin
            if (ph_q == PH_COARSE) begin
               corr_q <= err;
               ph_q   <= PH_FINE;
               strk_q <= '0;
            end else begin
               corr_q <= corr_q + trim[CORR_W-1:0];
               if (!resid_ok)         strk_q <= '0;
               else if (strk_q != SMAX) strk_q <= strk_q + STRK_W'(1);
            end
         end
         if (late_rej || !ref_ok) strk_q <= '0;
      end
   end

   assign corr    = corr_q;
   assign fine_ph = (ph_q == PH_FINE);
   assign locked  = (strk_q >= SMAX);
endmodule

// File: rtl/dtc_slew_sched.sv
module dtc_slew_sched #(
   parameter int unsigned NOM_CYCLES = 100_000_000,
   parameter int unsigned CORR_W     = 12,
   parameter int unsigned ACC_W      = 29
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     realign,
   input  logic signed [CORR_W-1:0] corr,
   output logic                     skip,
   output logic                     ins
);
   localparam logic [ACC_W-1:0] NOM_V = ACC_W'(NOM_CYCLES);

   logic [ACC_W-1:0]  acc_q, sum;
   logic [CORR_W-1:0] mag;
   logic              fire;

   always_comb begin
      mag  = corr[CORR_W-1] ? CORR_W'(-corr) : CORR_W'(corr);
      sum  = acc_q + ACC_W'(mag);
      fire = (sum >= NOM_V);
      skip = fire && !corr[CORR_W-1];
      ins  = fire && corr[CORR_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (realign) acc_q <= '0;
      else if (fire)    acc_q <= sum - NOM_V;
      else              acc_q <= sum;
   end
endmodule

// File: rtl/disc_time_counter.sv
module disc_time_counter #(
   parameter int unsigned NOM_CYCLES = 100_000_000,
   parameter int unsigned MAX_DEV    = 1000,
   parameter int unsigned MAX_TRIM   = 64,
   parameter int unsigned LOCK_THR   = 20,
   parameter int unsigned LOCK_SECS  = 4,
   parameter int unsigned SEC_W      = 32,
   localparam int unsigned SUB_W     = $clog2(NOM_CYCLES),
   localparam int unsigned CORR_W    = $clog2(MAX_DEV + 1) + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sec_strobe,
   input  logic                     ref_ok,
   output logic [SUB_W-1:0]         sub_count,
   output logic [SEC_W-1:0]         sec_count,
   output logic signed [CORR_W-1:0] corr_value,
   output logic                     locked
);
   localparam int unsigned CNT_W  = $clog2(NOM_CYCLES + MAX_DEV + 2) + 1;
   localparam int unsigned ACC_W  = $clog2(NOM_CYCLES) + 2;
   localparam int unsigned STRK_W = $clog2(LOCK_SECS + 1);
   localparam logic [SUB_W:0] NOM_V  = (SUB_W+1)'(NOM_CYCLES);
   localparam logic [SUB_W-1:0] HALF = SUB_W'(NOM_CYCLES / 2);

   if (MAX_DEV == 0 || 2 * MAX_DEV >= NOM_CYCLES) begin : g_bad_dev
      $error("MAX_DEV must be nonzero and below half of NOM_CYCLES");
   end
   if (MAX_TRIM == 0 || MAX_TRIM > MAX_DEV) begin : g_bad_trim
      $error("MAX_TRIM must lie in 1..MAX_DEV");
   end
   if (LOCK_THR > MAX_DEV || LOCK_SECS == 0) begin : g_bad_lock
      $error("lock threshold or count out of range");
   end
   if (SEC_W < 1 || NOM_CYCLES < 4) begin : g_bad_size
      $error("counter sizes out of range");
   end

   logic take, measured, late_rej, fine_ph, skip, ins;
   logic signed [CORR_W-1:0] err, corr;
   logic [SUB_W-1:0] sub_q;
   logic [SEC_W-1:0] sec_q;
   logic [SUB_W:0]   nxt;
   logic [1:0]       inc;

   dtc_interval_meter #(
      .NOM_CYCLES(NOM_CYCLES), .MAX_DEV(MAX_DEV), .CNT_W(CNT_W), .CORR_W(CORR_W)
   ) i_meter (
      .clk(clk), .rst_n(rst_n), .strobe(sec_strobe), .ref_ok(ref_ok),
      .take(take), .measured(measured), .late_rej(late_rej), .err(err)
   );

   dtc_corr_filter #(
      .CORR_W(CORR_W), .MAX_TRIM(MAX_TRIM), .LOCK_THR(LOCK_THR),
      .LOCK_SECS(LOCK_SECS), .STRK_W(STRK_W)
   ) i_filter (
      .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .measured(measured),
      .late_rej(late_rej), .err(err), .corr(corr), .fine_ph(fine_ph),
      .locked(locked)
   );

   dtc_slew_sched #(
      .NOM_CYCLES(NOM_CYCLES), .CORR_W(CORR_W), .ACC_W(ACC_W)
   ) i_sched (
      .clk(clk), .rst_n(rst_n), .realign(take), .corr(corr),
      .skip(skip), .ins(ins)
   );

   always_comb begin
      inc = skip ? 2'd0 : (ins ? 2'd2 : 2'd1);
      nxt = {1'b0, sub_q} + (SUB_W+1)'(inc);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         sec_q <= '0;
      end else if (take) begin
         sub_q <= '0;
         if (sub_q >= HALF) sec_q <= sec_q + SEC_W'(1);
      end else if (nxt >= NOM_V) begin
         sub_q <= SUB_W'(nxt - NOM_V);
         sec_q <= sec_q + SEC_W'(1);
      end else begin
         sub_q <= nxt[SUB_W-1:0];
      end
   end

   assign sub_count  = sub_q;
   assign sec_count  = sec_q;
   assign corr_value = corr;
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
   parameter int unsigned NOM_CYCLES = 1000,
   parameter int unsigned MAX_TRIM   = 8,
   parameter int unsigned SUB_W      = 10,
   parameter int unsigned CORR_W     = 10
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ref_ok,
   input logic                     take,
   input logic                     measured,
   input logic                     fine_ph,
   input logic signed [CORR_W-1:0] err,
   input logic [SUB_W-1:0]         sub_count,
   input logic signed [CORR_W-1:0] corr_value,
   input logic                     locked
);
   // R2
   sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sub_count) < int'(NOM_CYCLES));

   // R6
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ((int'(sub_count) + int'(NOM_CYCLES) - int'($past(sub_count)))
                 % int'(NOM_CYCLES)) <= 2);

   // R3
   realign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> sub_count == '0);

   // R4
   coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (measured && !fine_ph) |=> corr_value == $past(err));

   // R5
   trim_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (measured && fine_ph) |=>
         (int'(corr_value) - int'($past(corr_value)) <= int'(MAX_TRIM)) &&
         (int'($past(corr_value)) - int'(corr_value) <= int'(MAX_TRIM)));

   // R10
   corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !measured |=> $stable(corr_value));

   // R9
   lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_ok |=> !locked);
endmodule

bind disc_time_counter dtc_checker #(
   .NOM_CYCLES(NOM_CYCLES), .MAX_TRIM(MAX_TRIM), .SUB_W(SUB_W), .CORR_W(CORR_W)
) i_dtc_checker (
   .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .take(take), .measured(measured),
   .fine_ph(fine_ph), .err(err), .sub_count(sub_count), .corr_value(corr_value),
   .locked(locked)
);

// File: tb/test_disc_time_counter.sv
module test_disc_time_counter;
   localparam int CLK_PERIOD = 10;
   localparam int N      = 1000;
   localparam int DEV    = 200;
   localparam int TRIM   = 8;
   localparam int THR    = 2;
   localparam int SECS   = 3;
   localparam int SECW   = 16;
   localparam int SUBW   = $clog2(N);
   localparam int CORRW  = $clog2(DEV + 1) + 2;

   logic clk = 1'b0, rst_n = 1'b0, sec_strobe = 1'b0, ref_ok = 1'b0;
   logic [SUBW-1:0] sub_count;
   logic [SECW-1:0] sec_count;
   logic signed [CORRW-1:0] corr_value;
   logic locked;

   disc_time_counter #(
      .NOM_CYCLES(N), .MAX_DEV(DEV), .MAX_TRIM(TRIM), .LOCK_THR(THR),
      .LOCK_SECS(SECS), .SEC_W(SECW)
   ) i_disc_time_counter (
      .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe), .ref_ok(ref_ok),
      .sub_count(sub_count), .sec_count(sec_count), .corr_value(corr_value),
      .locked(locked)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 1'b0;
   longint since, base_sec, gap;
   int c_act, e_corr, streak;
   bit have_prev, fine;

   function automatic longint total_adv();
      if (c_act >= 0) return since - (since * c_act) / N;
      return since + (since * (-c_act)) / N;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_time(string tag);
      longint t;
      t = total_adv();
      chk({tag, " sub"}, longint'(sub_count), t % N);
      chk({tag, " sec"}, longint'(sec_count), base_sec + t / N);
   endtask

   task automatic chk_state(string tag);
      chk({tag, " corr"}, longint'(corr_value), e_corr);
      chk({tag, " lock"}, longint'(locked), longint'(streak >= SECS));
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
      since += n;
      gap   += n;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      since = 0; base_sec = 0; gap = 0; c_act = 0; e_corr = 0;
      streak = 0; have_prev = 1'b0; fine = 1'b0;
   endtask

   task automatic set_ref(bit v);
      ref_ok = v;
      step(1);
      if (!v) begin
         have_prev = 1'b0;
         streak = 0;
      end
   endtask

   task automatic pulse();
      longint t, pre_sub, pre_sec, interval;
      bit early, late, restart;
      int err_v, resid, trim;
      t = total_adv();
      pre_sub = t % N;
      pre_sec = base_sec + t / N;
      interval = gap + 1;
      early = have_prev && (interval < N - DEV);
      late  = have_prev && (interval > N + DEV);
      restart = ref_ok && !early;
      sec_strobe = 1'b1;
      @(negedge clk);
      sec_strobe = 1'b0;
      since += 1;
      gap += 1;
      if (restart) begin
         gap = 0;
         if (late) streak = 0;
         else begin
            base_sec = pre_sec + ((pre_sub >= N / 2) ? 1 : 0);
            since = 0;
            if (have_prev) begin
               err_v = int'(interval) - N;
               if (!fine) begin
                  e_corr = err_v;
                  fine = 1'b1;
                  streak = 0;
               end else begin
                  resid = err_v - e_corr;
                  trim = (resid > TRIM) ? TRIM : ((resid < -TRIM) ? -TRIM : resid);
                  e_corr += trim;
                  if (resid <= THR && resid >= -THR) begin
                     if (streak < SECS) streak++;
                  end else streak = 0;
               end
            end
            c_act = e_corr;
         end
         have_prev = 1'b1;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 sub", longint'(sub_count), 0);
      chk("R1 sec", longint'(sec_count), 0);
      chk_state("R1");
      set_ref(1'b1);
      step(698);
      chk_time("R2 free run");
      // R3 first strobe only realigns
      pulse();
      chk_time("R3 first realign");
      chk_state("R3");
      // R4 coarse step, then R2 wrap without correction seen before it
      step(1098); pulse();
      chk_time("R4 realign");
      chk_state("R4 coarse");
      // R5 fine trims: clamped +9 -> +8, then +1, -2, 0
      step(1107); pulse(); chk_state("R5 clamp");
      step(1107); pulse(); chk_state("R5 fine up");
      step(1105); pulse(); chk_state("R5 fine down");
      step(1105); pulse(); chk_state("R9 lock set");
      chk("R9 locked", longint'(locked), 1);
      // R6 spreading of a positive correction
      step(1);   chk_time("R6 j1");
      step(9);   chk_time("R6 j10");
      step(490); chk_time("R6 j500");
      // R7 early glitch ignored
      pulse();
      chk_time("R7 glitch");
      chk_state("R7 glitch");
      step(604); pulse();
      chk_time("R7 after glitch");
      chk_state("R7 after glitch");
      // R8 late strobe
      step(1349); pulse();
      chk_time("R8 late");
      chk_state("R8 late");
      step(1105); pulse();
      chk_time("R8 new base");
      chk_state("R8 new base");
      // R10 holdover
      set_ref(1'b0);
      chk_state("R9 ref drop");
      step(700); pulse();
      chk_time("R10 strobe ignored");
      chk_state("R10 strobe ignored");
      step(1800);
      chk_time("R10 holdover");
      set_ref(1'b1);
      step(300); pulse();
      chk_time("R10 reacquire");
      chk_state("R10 reacquire");
      // R4/R6 negative correction after a fresh reset
      do_reset();
      chk_state("R1 second reset");
      set_ref(1'b1);
      step(10); pulse();
      step(949); pulse();
      chk_state("R4 negative coarse");
      step(20);  chk_time("R6 neg j20");
      step(939); chk_time("R6 neg j959");
      step(21);  chk_time("R6 neg wrap");
      step(59);  pulse();
      chk_time("R3 slow realign");
      chk_state("R5 neg fine");
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule